// File: doc/BRIEF.md
# Keyed Write-Protection Lock for Configuration Registers

This block guards a small bank of 32-bit configuration registers behind a lock that software opens and closes by writing key words. It sits between a single-cycle register write port and the protected bank. Word index 0 is the lock control word. Every other mapped index is a configuration register. Each write is either accepted or dropped, depending on the current lock state. A dropped write leaves every register as it was and raises a one-cycle error pulse.

The lock has three states. Soft lock is the state after reset: only the lock control word accepts writes. Open accepts every write. Sealed drops every write, including writes to the lock control word, and only a reset leaves it. Reads are combinational and are never gated by the lock. Software can therefore always read the lock state and the stored configuration.

Top module: `cfg_guard_top`

## Requirements
- R1: While rst_n is low and directly after it is released, the lock is soft, word index 0 reads 0x00000000, every configuration register reads 0 and drop_err is low.
- R2: A write of 0xFC600309 to word index 0 opens the lock when the lock is not sealed. Word index 0 then reads 0x00000001 from the cycle after that write.
- R3: A write of 0xDEADDEAD to word index 0 seals the lock when the lock is not sealed. Word index 0 then reads 0x00000010 from the cycle after that write.
- R4: A write of any other value to word index 0 soft-locks the lock when the lock is not sealed, from either open or soft. Word index 0 then reads 0x00000000.
- R5: While soft-locked, a write to any index other than 0 is dropped and leaves every configuration register unchanged.
- R6: While soft-locked, writes to word index 0 are accepted and do not raise drop_err. This means the lock can be opened or sealed from soft lock.
- R7: While sealed, every write is dropped, including writes to word index 0 carrying either key. Only rst_n low returns the lock to soft.
- R8: While open, a write to word index k (1 to NUM_CFG) stores the data, and a read of index k returns it from the cycle after the write.
- R9: drop_err is high for exactly the one cycle after each dropped write, and it is never high after an accepted write. Back-to-back dropped writes keep it high once for each write.
- R10: Reads of every index return the current contents in every lock state, including while sealed.
- R11: While open, a write to an unmapped index (above NUM_CFG) changes nothing and raises no error. A read of an unmapped index returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_idx | input | ADDR_W | Word index of the write (0 = lock control word) |
| wr_data | input | 32 | Write data |
| rd_idx | input | ADDR_W | Word index of the combinational read |
| rd_data | output | 32 | Read data for rd_idx |
| drop_err | output | 1 | One-cycle pulse after a dropped write |

## Verification
The bench builds the block with ADDR_W = 4 and NUM_CFG = 4. This gives a 16-word index space in which the last mapped register (index 4) and the first unmapped index (5) can both be reached. With these values the vector walk can fill every configuration register and then probe the boundary just past the bank. It also covers a near-miss key that differs from the unlock key in one bit. It can then check that a seal freezes every stored value while the contents stay readable.

// File: rtl/wplock_pkg.sv
package wplock_pkg;

  localparam int WORD_W = 32;

  // Lock state encoding; at most one bit set in any state
  typedef enum logic [1:0] {
    LK_SOFT = 2'b00,
    LK_OPEN = 2'b01,
    LK_HARD = 2'b10
  } lock_e;

  localparam logic [WORD_W-1:0] KEY_OPEN = 32'hFC60_0309;
  localparam logic [WORD_W-1:0] KEY_SEAL = 32'hDEAD_DEAD;

  localparam logic [WORD_W-1:0] RB_SOFT = 32'h0000_0000;
  localparam logic [WORD_W-1:0] RB_OPEN = 32'h0000_0001;
  localparam logic [WORD_W-1:0] RB_HARD = 32'h0000_0010;

  function automatic lock_e key_decode(input logic [WORD_W-1:0] d);
    if (d == KEY_OPEN)      return LK_OPEN;
    else if (d == KEY_SEAL) return LK_HARD;
    else                    return LK_SOFT;
  endfunction

  function automatic logic [WORD_W-1:0] lock_readback(input lock_e s);
    case (s)
      LK_OPEN: return RB_OPEN;
      LK_HARD: return RB_HARD;
      default: return RB_SOFT;
    endcase
  endfunction

endpackage

// File: rtl/wplock_ctrl.sv
module wplock_ctrl
  import wplock_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output lock_e             state_o,
  output logic              wr_pass_o,
  output logic              drop_err_o
);

  lock_e state_q, state_d;
  logic  err_q, err_d;
  logic  is_ctl;
  logic  pass;

  assign is_ctl = (wr_idx == '0);

  // Gate decision
  always_comb begin
    case (state_q)
      LK_OPEN: pass = 1'b1;
      LK_SOFT: pass = is_ctl;
      default: pass = 1'b0;
    endcase
  end

  // Next state and error pulse
  always_comb begin
    state_d = state_q;
    if (wr_en && pass && is_ctl) begin
      state_d = key_decode(wr_data);
    end
    err_d = wr_en && !pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_SOFT;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign state_o    = state_q;
  assign wr_pass_o  = pass;
  assign drop_err_o = err_q;

  AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_HARD) |=> (state_q == LK_HARD)); // R7

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(state_q)); // R4

  AST_OPEN_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ctl && wr_data == KEY_OPEN && state_q != LK_HARD) |=> (state_q == LK_OPEN)); // R2

  AST_SEAL_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ctl && wr_data == KEY_SEAL) |=> (state_q == LK_HARD)); // R3

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import wplock_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_CFG = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            wr_pass,
  input  logic [ADDR_W-1:0]               wr_idx,
  input  logic [WORD_W-1:0]               wr_data,
  output logic [NUM_CFG-1:0][WORD_W-1:0]  cfg_o
);

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_reg
    logic              load;
    logic [WORD_W-1:0] val_q, val_d;

    assign load = wr_en && wr_pass && (wr_idx == ADDR_W'(k + 1));

    always_comb begin
      val_d = val_q;
      if (load) val_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign cfg_o[k] = val_q;
  end

endmodule

// File: rtl/cfg_rdmux.sv
module cfg_rdmux
  import wplock_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_CFG = 4
) (
  input  logic [ADDR_W-1:0]              rd_idx,
  input  lock_e                          state,
  input  logic [NUM_CFG-1:0][WORD_W-1:0] cfg,
  output logic [WORD_W-1:0]              rd_data
);

  always_comb begin
    rd_data = '0;
    if (rd_idx == '0) begin
      rd_data = lock_readback(state);
    end
    for (int k = 0; k < NUM_CFG; k++) begin
      if (rd_idx == ADDR_W'(k + 1)) rd_data = cfg[k];
    end
  end

endmodule

// File: rtl/cfg_guard_top.sv
module cfg_guard_top
  import wplock_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_CFG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [31:0]       rd_data,
  output logic              drop_err
);

  lock_e                          state;
  logic                           wr_pass;
  logic [NUM_CFG-1:0][WORD_W-1:0] cfg;

  wplock_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .state_o    (state),
    .wr_pass_o  (wr_pass),
    .drop_err_o (drop_err)
  );

  cfg_bank #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_pass (wr_pass),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cfg_o   (cfg)
  );

  cfg_rdmux #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) u_rd (
    .rd_idx  (rd_idx),
    .state   (state),
    .cfg     (cfg),
    .rd_data (rd_data)
  );

  AST_LOCKED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LK_OPEN) |=> $stable(cfg)); // R5

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |-> $past(wr_en)); // R9

  AST_NO_ERR_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_OPEN) |=> !drop_err); // R8

endmodule

// File: tb/sim_cfg_guard_top.sv
`timescale 1ns/1ps
module sim_cfg_guard_top;

  localparam int AW = 4;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_idx = '0;
  logic [31:0]   rd_data;
  logic          drop_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_guard_top #(.ADDR_W(AW), .NUM_CFG(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .drop_err(drop_err)
  );

  typedef struct packed {
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 32'h1111_1111, 4'd1, 32'h0000_0000, 1'b1, 8'd5},  // R5 soft drops cfg write
    '{4'd0, 32'h1234_5678, 4'd0, 32'h0000_0000, 1'b0, 8'd6},  // R6 control word writable
    '{4'd0, 32'hFC60_0309, 4'd0, 32'h0000_0001, 1'b0, 8'd2},  // R2 open
    '{4'd1, 32'hA5A5_A5A5, 4'd1, 32'hA5A5_A5A5, 1'b0, 8'd8},  // R8
    '{4'd2, 32'h0000_0002, 4'd2, 32'h0000_0002, 1'b0, 8'd8},  // R8
    '{4'd3, 32'hFFFF_FFFF, 4'd3, 32'hFFFF_FFFF, 1'b0, 8'd8},  // R8
    '{4'd4, 32'h1357_9BDF, 4'd4, 32'h1357_9BDF, 1'b0, 8'd8},  // R8 last register
    '{4'd5, 32'hCAFE_F00D, 4'd5, 32'h0000_0000, 1'b0, 8'd11}, // R11 unmapped
    '{4'd0, 32'hFC60_0308, 4'd0, 32'h0000_0000, 1'b0, 8'd4},  // R4 near-miss key
    '{4'd2, 32'h0000_0077, 4'd2, 32'h0000_0002, 1'b1, 8'd5},  // R5
    '{4'd0, 32'hFC60_0309, 4'd0, 32'h0000_0001, 1'b0, 8'd6},  // R6 reopen from soft
    '{4'd0, 32'hDEAD_DEAD, 4'd0, 32'h0000_0010, 1'b0, 8'd3},  // R3 seal
    '{4'd0, 32'hFC60_0309, 4'd0, 32'h0000_0010, 1'b1, 8'd7},  // R7 key ignored
    '{4'd3, 32'h0000_0000, 4'd3, 32'hFFFF_FFFF, 1'b1, 8'd7},  // R7 cfg frozen, R10 readable
    '{4'd0, 32'h0000_0000, 4'd0, 32'h0000_0010, 1'b1, 8'd7}   // R7 soft value ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    rd_idx = a;
    #0.5;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rd_chk("R1 ctl in reset", 0, 32'h0);
    check("R1 err in reset", {31'b0, drop_err}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 ctl after reset", 0, 32'h0);
    for (int k = 1; k <= NC; k++) rd_chk("R1 cfg after reset", AW'(k), 32'h0);
    check("R1 err after reset", {31'b0, drop_err}, 32'h0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      wr(VECS[i].wa, VECS[i].wd);
      tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      #0.5;
      check({tag, " err"}, {31'b0, drop_err}, {31'b0, VECS[i].exp_err});
      rd_chk({tag, " rd"}, VECS[i].ra, VECS[i].exp_rd);
    end

    // R9 pulse ends after one cycle
    @(negedge clk); #0.5;
    check("R9 err clears", {31'b0, drop_err}, 32'h0);

    // R9 back-to-back drops while sealed
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'h0;
    @(negedge clk);
    wr_idx = 4'd2; #0.5;
    check("R9 first drop", {31'b0, drop_err}, 32'h1);
    @(negedge clk);
    wr_en = 1'b0; #0.5;
    check("R9 second drop", {31'b0, drop_err}, 32'h1);
    @(negedge clk); #0.5;
    check("R9 pulse over", {31'b0, drop_err}, 32'h0);

    // R10 reads while sealed
    rd_chk("R10 cfg1 sealed", 1, 32'hA5A5_A5A5);
    rd_chk("R10 cfg2 sealed", 2, 32'h0000_0002);
    rd_chk("R10 cfg4 sealed", 4, 32'h1357_9BDF);
    rd_chk("R11 unmapped read", 9, 32'h0);

    // R7 only reset leaves seal; R1 reset clears bank
    @(negedge clk) rst_n = 1'b0;
    #0.5;
    rd_chk("R7 reset unseals", 0, 32'h0);
    rd_chk("R1 cfg1 cleared", 1, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R4 open -> soft via arbitrary value
    wr(0, 32'hFC60_0309);
    rd_chk("R2 open again", 0, 32'h1);
    wr(0, 32'h0000_0001);
    #0.5;
    check("R4 no err", {31'b0, drop_err}, 32'h0);
    rd_chk("R4 soft from open", 0, 32'h0);

    // R6 seal directly from soft
    wr(0, 32'hDEAD_DEAD);
    rd_chk("R6 seal from soft", 0, 32'h10);
    wr(4, 32'h5555_5555);
    rd_chk("R7 cfg4 unchanged", 4, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule